// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is an 8-bit general-purpose I/O port whose pins can each raise an edge-triggered interrupt. A byte-wide register bus reaches seven registers: the synchronized pin levels, the output latch, the direction mask, the pending-flag vector, the per-pin edge polarity, the per-pin request enable and the per-pin function select. Output, direction and function-select values go straight to the pad ring and the alternate-function mux, neither of which is part of this block.

Each pin goes through a two-flop synchronizer. After that, a comparison with the previous sampled value finds transitions. A transition of the chosen polarity sets a sticky pending flag. Software can also set a flag by writing 1, and clears it by writing 0. One request line is high whenever any flag with its enable bit set is pending. A service routine that clears only the flags it handled therefore sees the line come back for any edge that arrived in the meantime.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every register reads 0, `pad_oe`, `pad_out` and `pad_fsel` are 0 and `irq` is low.
- R2: Register offsets are 0 pin level (read-only; writes are ignored), 1 output, 2 direction, 3 flags, 4 edge polarity, 5 request enable and 6 function select. Offsets 1, 2, 4, 5 and 6 read back the last value written. Offset 7 reads 0.
- R3: `pad_out`, `pad_oe` and `pad_fsel` equal the output, direction and function-select registers from the cycle after the write.
- R4: Offset 0 returns the pin level after two flops. A pin change driven before clock edge k is readable after edge k+1 and not after edge k.
- R5: With polarity bit 0, a low-to-high transition sets that pin's flag and a high-to-low transition does not.
- R6: With polarity bit 1, a high-to-low transition sets the flag and a low-to-high transition does not.
- R7: A static level never sets a flag. This covers a pin held high through reset and a change of polarity bits while the pin is steady.
- R8: A write to offset 3 clears each flag bit written 0 and sets each bit written 1. A flag set by software requests an interrupt exactly as an edge-set flag does.
- R9: When a qualifying edge and a write of 0 to the same flag bit take effect on the same clock edge, the flag stays set.
- R10: `irq` is high exactly when some pin has both its flag and its enable bit set. An enable bit of 0 blocks the request but still lets the flag be set.
- R11: A pin pulse lasting two clock cycles is detected and sets its flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 8 | Asynchronous pin levels |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_out | output | 8 | Output latch value to pads |
| pad_oe | output | 8 | Per-pin output enable (1 = drive) |
| pad_fsel | output | 8 | Per-pin alternate-function select |
| irq | output | 1 | Combined port interrupt request |

## Verification
The assertions assume that `bus_wr`, `bus_addr` and `bus_wdata` are stable across each rising clock edge. They also assume that a pin change is seen by the first flop at one edge and does not glitch back within that cycle. The bench drives every bus signal and pin on the falling edge, so each change is settled half a period before the edge that captures it. Pulses are held for whole cycles, never shorter than two.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
    localparam int PORT_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        OFS_LEVEL = 3'd0,
        OFS_OUT   = 3'd1,
        OFS_DIR   = 3'd2,
        OFS_FLAG  = 3'd3,
        OFS_POL   = 3'd4,
        OFS_EN    = 3'd5,
        OFS_FSEL  = 3'd6,
        OFS_NONE  = 3'd7
    } port_ofs_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
    parameter int WIDTH = 8,
    parameter int FILL  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    input  logic [WIDTH-1:0] pol_i,
    output logic [WIDTH-1:0] hit_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [FILL-1:0]  armed;
    } det_state_t;

    det_state_t st_d, st_q;
    logic [WIDTH-1:0] rise_w, fall_w;

    // A pipeline that is still filling after reset must not report its
    // first nonzero sample as an edge.
    always_comb begin
        st_d       = st_q;
        st_d.prev  = level_i;
        st_d.armed = {st_q.armed[FILL-2:0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_pin
            assign rise_w[b] =  level_i[b] & ~st_q.prev[b];
            assign fall_w[b] = ~level_i[b] &  st_q.prev[b];
            assign hit_o[b]  = st_q.armed[FILL-1] &
                               (pol_i[b] ? fall_w[b] : rise_w[b]);
        end
    endgenerate
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  level_i,
    input  logic [WIDTH-1:0]  hit_i,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  out_o,
    output logic [WIDTH-1:0]  dir_o,
    output logic [WIDTH-1:0]  flag_o,
    output logic [WIDTH-1:0]  pol_o,
    output logic [WIDTH-1:0]  en_o,
    output logic [WIDTH-1:0]  fsel_o
);
    typedef struct packed {
        logic [WIDTH-1:0] out;
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] flag;
        logic [WIDTH-1:0] pol;
        logic [WIDTH-1:0] en;
        logic [WIDTH-1:0] fsel;
    } regs_t;

    regs_t r_d, r_q;
    port_ofs_e ofs;

    assign ofs = port_ofs_e'(bus_addr);

    always_comb begin
        r_d      = r_q;
        r_d.flag = r_q.flag | hit_i;
        if (bus_wr) begin
            case (ofs)
                OFS_OUT:  r_d.out  = bus_wdata;
                OFS_DIR:  r_d.dir  = bus_wdata;
                // hardware edges are ORed last so they survive a clear
                OFS_FLAG: r_d.flag = bus_wdata | hit_i;
                OFS_POL:  r_d.pol  = bus_wdata;
                OFS_EN:   r_d.en   = bus_wdata;
                OFS_FSEL: r_d.fsel = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (ofs)
            OFS_LEVEL: bus_rdata = level_i;
            OFS_OUT:   bus_rdata = r_q.out;
            OFS_DIR:   bus_rdata = r_q.dir;
            OFS_FLAG:  bus_rdata = r_q.flag;
            OFS_POL:   bus_rdata = r_q.pol;
            OFS_EN:    bus_rdata = r_q.en;
            OFS_FSEL:  bus_rdata = r_q.fsel;
            default:   bus_rdata = '0;
        endcase
    end

    assign out_o  = r_q.out;
    assign dir_o  = r_q.dir;
    assign flag_o = r_q.flag;
    assign pol_o  = r_q.pol;
    assign en_o   = r_q.en;
    assign fsel_o = r_q.fsel;
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH      = PORT_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WIDTH-1:0]  pin_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_fsel,
    output logic              irq
);
    localparam int ARM_DEPTH = SYNC_DEPTH + 1;

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] flag_vec, pol_vec, en_vec;

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    gpio_edge_detect #(.WIDTH(WIDTH), .FILL(ARM_DEPTH)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (pin_sync),
        .pol_i   (pol_vec),
        .hit_o   (edge_hit)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .level_i   (pin_sync),
        .hit_i     (edge_hit),
        .bus_rdata (bus_rdata),
        .out_o     (pad_out),
        .dir_o     (pad_oe),
        .flag_o    (flag_vec),
        .pol_o     (pol_vec),
        .en_o      (en_vec),
        .fsel_o    (pad_fsel)
    );

    assign irq = |(flag_vec & en_vec);
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [WIDTH-1:0]  bus_wdata,
    input logic [WIDTH-1:0]  pad_oe,
    input logic              irq,
    input logic [WIDTH-1:0]  flag_vec,
    input logic [WIDTH-1:0]  edge_hit,
    input logic [WIDTH-1:0]  pin_sync
);
    logic flag_wr;
    assign flag_wr = bus_wr && (bus_addr == OFS_FLAG);

    // R3
    dir_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIR) |=> (pad_oe == $past(bus_wdata)));

    // R8
    sw_set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_wr |=> (($past(bus_wdata) & ~flag_vec) == '0));

    // R7
    flag_rise_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flag_vec & ~$past(flag_vec) & ~$past(edge_hit)) == '0));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> (($past(flag_vec) & ~flag_vec) == '0));

    // R5
    hit_only_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit & ~(pin_sync ^ $past(pin_sync))) == '0);

    // R10
    irq_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !bus_wr) |=> irq);
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pad_oe    (pad_oe),
    .irq       (irq),
    .flag_vec  (flag_vec),
    .edge_hit  (edge_hit),
    .pin_sync  (pin_sync)
);

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pad_out, pad_oe, pad_fsel;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    gpio_edge_port dut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_fsel(pad_fsel), .irq(irq)
    );

    typedef struct packed {
        logic [7:0] pol;
        logic [7:0] en;
        logic [7:0] lvl_a;
        logic [7:0] lvl_b;
        logic [7:0] flg;
        logic       req;
    } vec_t;

    // R5 R6 R10: polarity, enable, start level, end level, expected flags, request
    localparam vec_t VEC [6] = '{
        '{8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 1'b1},
        '{8'hFF, 8'hFF, 8'h00, 8'hFF, 8'h00, 1'b0},
        '{8'hFF, 8'h0F, 8'hFF, 8'h00, 8'hFF, 1'b1},
        '{8'hF0, 8'h00, 8'hA5, 8'h5A, 8'hAA, 1'b0},
        '{8'h0F, 8'h80, 8'h3C, 8'hC3, 8'hCC, 1'b1},
        '{8'h55, 8'h11, 8'h00, 8'h00, 8'h00, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(4);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], v);
            check($sformatf("R1 reset read ofs %0d", a), v, 8'h00);
        end
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_fsel", pad_fsel, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);

        // R2 R3 register access
        wr(3'd1, 8'h3C); wr(3'd2, 8'hC5); wr(3'd6, 8'h96);
        wr(3'd4, 8'h12); wr(3'd5, 8'h00); wr(3'd0, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd1, v); check("R2 out readback", v, 8'h3C);
        rd(3'd2, v); check("R2 dir readback", v, 8'hC5);
        rd(3'd6, v); check("R2 fsel readback", v, 8'h96);
        rd(3'd4, v); check("R2 pol readback", v, 8'h12);
        rd(3'd0, v); check("R2 level write ignored", v, 8'h00);
        rd(3'd7, v); check("R2 unused offset", v, 8'h00);
        check("R3 pad_out", pad_out, 8'h3C);
        check("R3 pad_oe", pad_oe, 8'hC5);
        check("R3 pad_fsel", pad_fsel, 8'h96);
        wr(3'd3, 8'h00);

        // R4 synchronizer latency
        @(negedge clk); pin_i = 8'h5A; bus_addr = 3'd0;
        @(negedge clk); #0.5 check("R4 level after one edge", bus_rdata, 8'h00);
        @(negedge clk); #0.5 check("R4 level after two edges", bus_rdata, 8'h5A);
        idle(2); pin_i = 8'h00; idle(4);

        // R5 R6 R10 vector table
        for (int i = 0; i < 6; i++) begin
            wr(3'd5, 8'h00);
            wr(3'd4, VEC[i].pol);
            @(negedge clk); pin_i = VEC[i].lvl_a;
            idle(5);
            wr(3'd3, 8'h00);
            wr(3'd5, VEC[i].en);
            @(negedge clk); pin_i = VEC[i].lvl_b;
            idle(5);
            rd(3'd3, v);
            check($sformatf("R5/R6 vector %0d flags", i), v, VEC[i].flg);
            check($sformatf("R10 vector %0d irq", i), {7'b0, irq}, {7'b0, VEC[i].req});
        end

        // R7 polarity change with steady pins
        wr(3'd5, 8'h00); wr(3'd4, 8'h00);
        @(negedge clk); pin_i = 8'hF0; idle(5);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'hFF); idle(3); wr(3'd4, 8'h00); idle(3);
        rd(3'd3, v); check("R7 polarity change no flag", v, 8'h00);

        // R7 pin high through reset
        @(negedge clk); pin_i = 8'hFF; rst_n = 1'b0; idle(3);
        rst_n = 1'b1; idle(8);
        rd(3'd3, v); check("R7 level through reset", v, 8'h00);

        // R8 software set / clear and request
        wr(3'd5, 8'h04);
        wr(3'd3, 8'h84);
        rd(3'd3, v); check("R8 sw set", v, 8'h84);
        check("R8 sw set requests", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h80);
        rd(3'd3, v); check("R8 sw clear", v, 8'h80);
        check("R10 disabled flag no request", {7'b0, irq}, 8'h00);
        wr(3'd5, 8'h80);
        check("R10 enable raises request", {7'b0, irq}, 8'h01);
        wr(3'd3, 8'h00);
        check("R10 clear drops request", {7'b0, irq}, 8'h00);

        // R9 edge coincides with clearing write (pins at FF, polarity 0)
        wr(3'd4, 8'h01);
        @(negedge clk); pin_i = 8'hFE;          // bit0 falls
        @(negedge clk);
        @(negedge clk); bus_addr = 3'd3; bus_wdata = 8'h00; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        rd(3'd3, v); check("R9 edge beats clear", v, 8'h01);
        wr(3'd3, 8'h00);

        // R11 two-cycle pulse, rising polarity
        wr(3'd4, 8'h00); wr(3'd5, 8'h02);
        @(negedge clk); pin_i = 8'h00; idle(5);
        wr(3'd3, 8'h00);
        @(negedge clk); pin_i = 8'h02;
        @(negedge clk);
        @(negedge clk); pin_i = 8'h00;
        idle(5);
        rd(3'd3, v); check("R11 short pulse flag", v, 8'h02);
        check("R11 short pulse irq", {7'b0, irq}, 8'h01);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule